// File: doc/BRIEF.md
# Modem-Line Event Mask and Wake Logic

This block sits behind the synchronisers of a serial port. It watches four modem-status lines and the serial receive line, and it turns their changes into requests for three consumers. The first is a single-cycle modem-status interrupt request, which goes to the interrupt arbiter. The second is an active-low power-management event request that stays asserted until it is acknowledged. The third is a single-cycle wake pulse for the auto-sleep controller.

A per-line mask register decides which line changes count. One mask bit per modem line removes that line's events from all three consumers at once. A separate mask bit controls the serial receive line. A start bit on that line can only raise the power-management event, and only while the device sits in low-power state D2.

The detector on each line stays quiet for the first clock after reset. This keeps the block from reporting a change against the reset value of its sample register. All three outputs are registered, so every response shows up one clock after the line change is first sampled.

Top module: `modem_wake_mask`

## Requirements
- R1: After reset, `modemIrq` and `wakeReq` are 0 and `pmeN` is 1. The first clock after reset only captures the lines and reports no event, whatever levels the lines hold.
- R2: Any change of CTS, DSR or DCD in either direction since the previous clock is an event. Its effect appears on the outputs one clock after the change is sampled.
- R3: On the RI line, only a change from 1 to 0 is an event. A change from 0 to 1 produces no output.
- R4: An unmasked modem-line event drives `modemIrq` high for exactly one clock, and only when `modemIntEn` is 1.
- R5: An unmasked modem-line event drives `pmeN` low when `inD2` is 1. `pmeN` then stays low until a clock on which `pmeAck` is 1 and no new event is present.
- R6: An unmasked modem-line event drives `wakeReq` high for exactly one clock, and only while `sleeping` is 1.
- R7: The mask bit for a line suppresses that line's interrupt, power-management event and wake request. The mask bits are: bit 0 for CTS, bit 1 for DSR, bit 2 for the falling edge of RI, and bit 3 for DCD.
- R8: A 1-to-0 transition on `serialIn` (a start bit) drives `pmeN` low only when `inD2` is 1 and mask bit 5 is 0. It never raises `modemIrq` or `wakeReq`.
- R9: Mask bits 4, 6 and 7 are reserved and have no effect on any output.
- R10: When a new power-management event and `pmeAck` arrive on the same clock, the event wins and `pmeN` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctsIn | input | 1 | Synchronised clear-to-send line |
| dsrIn | input | 1 | Synchronised data-set-ready line |
| riIn | input | 1 | Synchronised ring-indicator line |
| dcdIn | input | 1 | Synchronised carrier-detect line |
| serialIn | input | 1 | Synchronised serial receive line (idle high) |
| maskReg | input | 8 | Event mask: bits 0..3 modem lines, bit 5 start bit, bits 4, 6 and 7 reserved |
| modemIntEn | input | 1 | Modem-status interrupt enable |
| inD2 | input | 1 | Device is in low-power state D2 |
| sleeping | input | 1 | Serial port is asleep under auto-sleep |
| pmeAck | input | 1 | Acknowledge that clears the held power-management request |
| modemIrq | output | 1 | One-clock modem-status interrupt request |
| pmeN | output | 1 | Power-management event request, active low, held |
| wakeReq | output | 1 | One-clock wake pulse |

## Verification
Each modem line is toggled in both directions. This separates the any-change detectors from the RI detector, which must ignore a rising edge. The same kind of toggle is then repeated under each gate on its own: the interrupt enable cleared, the sleeping flag set, D2 entered, and each mask bit set in turn. Those runs show that each gate steers exactly one consumer, and that a mask bit silences all three. Start bits are sent with D2 on and off and with their mask bit on and off. Together with a line that is high while reset is released, an acknowledge that coincides with a new event, and a mask with only reserved bits set, these runs cover the priming cycle, the set-over-clear priority and the reserved bits.

// File: rtl/modem_wake_pkg.sv
package modem_wake_pkg;
  localparam int LINE_CNT = 4;
  localparam int RI_IDX = 2;

  typedef struct packed {
    logic [LINE_CNT-1:0] lineEv;
    logic                startEv;
  } evStrobe_t;
endpackage

// File: rtl/modem_edge_dp.sv
module modem_edge_dp
  import modem_wake_pkg::*;
#(
  parameter int NLINES = LINE_CNT,
  parameter int FALL_ONLY_IDX = RI_IDX
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NLINES-1:0] lines,
  input  logic              serialIn,
  output evStrobe_t         ev
);
  logic [NLINES-1:0] lineQ;
  logic [NLINES-1:0] evRaw;
  logic              serialQ;
  logic              primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ   <= '0;
      serialQ <= 1'b1;
      primed  <= 1'b0;
    end else begin
      lineQ   <= lines;
      serialQ <= serialIn;
      primed  <= 1'b1;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_det
    if (i == FALL_ONLY_IDX) begin : g_fall
      assign evRaw[i] = lineQ[i] & ~lines[i];
    end else begin : g_any
      assign evRaw[i] = lineQ[i] ^ lines[i];
    end
  end

  always_comb begin
    ev.lineEv  = primed ? evRaw : '0;
    ev.startEv = primed & serialQ & ~serialIn;
  end
endmodule

// File: rtl/wake_req_ctl.sv
module wake_req_ctl
  import modem_wake_pkg::*;
#(
  parameter int NLINES = LINE_CNT,
  parameter int START_MASK_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  evStrobe_t         ev,
  input  logic [NLINES-1:0] lineMask,
  input  logic              startMask,
  input  logic              modemIntEn,
  input  logic              inD2,
  input  logic              sleeping,
  input  logic              pmeAck,
  output logic              modemIrq,
  output logic              pmeN,
  output logic              wakeReq
);
  logic modemEv;
  logic startLive;
  logic pmeSet;
  logic pmeHeld;

  assign modemEv   = |(ev.lineEv & ~lineMask);
  assign startLive = ev.startEv & ~startMask;
  assign pmeSet    = inD2 & (modemEv | startLive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modemIrq <= 1'b0;
      wakeReq  <= 1'b0;
      pmeHeld  <= 1'b0;
    end else begin
      modemIrq <= modemEv & modemIntEn;
      wakeReq  <= modemEv & sleeping;
      if (pmeSet)      pmeHeld <= 1'b1;
      else if (pmeAck) pmeHeld <= 1'b0;
    end
  end

  assign pmeN = ~pmeHeld;
endmodule

// File: rtl/modem_wake_mask.sv
module modem_wake_mask
  import modem_wake_pkg::*;
#(
  parameter int MASK_W = 8,
  parameter int START_MASK_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              riIn,
  input  logic              dcdIn,
  input  logic              serialIn,
  input  logic [MASK_W-1:0] maskReg,
  input  logic              modemIntEn,
  input  logic              inD2,
  input  logic              sleeping,
  input  logic              pmeAck,
  output logic              modemIrq,
  output logic              pmeN,
  output logic              wakeReq
);
  evStrobe_t           ev;
  logic [LINE_CNT-1:0] lineVec;
  logic                unusedMaskBits;

  assign lineVec = {dcdIn, riIn, dsrIn, ctsIn};
  assign unusedMaskBits = ^{maskReg[MASK_W-1:START_MASK_BIT+1], maskReg[START_MASK_BIT-1:LINE_CNT]};

  modem_edge_dp #(.NLINES(LINE_CNT), .FALL_ONLY_IDX(RI_IDX)) dp_i (
    .clk(clk), .rstN(rstN), .lines(lineVec), .serialIn(serialIn), .ev(ev)
  );

  wake_req_ctl #(.NLINES(LINE_CNT), .START_MASK_BIT(START_MASK_BIT)) ctl_i (
    .clk(clk), .rstN(rstN), .ev(ev),
    .lineMask(maskReg[LINE_CNT-1:0]), .startMask(maskReg[START_MASK_BIT]),
    .modemIntEn(modemIntEn), .inD2(inD2), .sleeping(sleeping), .pmeAck(pmeAck),
    .modemIrq(modemIrq), .pmeN(pmeN), .wakeReq(wakeReq)
  );
endmodule

// File: rtl/modem_wake_mask_chk.sv
module modem_wake_mask_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctsIn,
  input logic       dsrIn,
  input logic       riIn,
  input logic       dcdIn,
  input logic       serialIn,
  input logic [7:0] maskReg,
  input logic       modemIntEn,
  input logic       inD2,
  input logic       sleeping,
  input logic       pmeAck,
  input logic       modemIrq,
  input logic       pmeN,
  input logic       wakeReq
);
  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    modemIrq |-> $past(modemIntEn));

  p_wake_needs_sleep_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(sleeping));

  p_pme_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!pmeN && !pmeAck) |=> !pmeN);

  p_pme_only_d2_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pmeN) |-> $past(inD2));

  p_all_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskReg[3:0]) == 4'hF) |-> (!modemIrq && !wakeReq));

  p_ack_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pmeAck && !pmeN && inD2 && maskReg[0] == 1'b0 && ctsIn != $past(ctsIn)) |=> !pmeN);
endmodule

bind modem_wake_mask modem_wake_mask_chk chk_i (.*);

// File: tb/modem_wake_mask_tb_top.sv
module modem_wake_mask_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctsIn, dsrIn, riIn, dcdIn, serialIn;
  logic [7:0] maskReg;
  logic modemIntEn, inD2, sleeping, pmeAck;
  logic modemIrq, pmeN, wakeReq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int    tgt;
    bit    irq;
    bit    wake;
    bit    pmeLow;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  modem_wake_mask dut_i (
    .clk(clk), .rstN(rstN), .ctsIn(ctsIn), .dsrIn(dsrIn), .riIn(riIn), .dcdIn(dcdIn),
    .serialIn(serialIn), .maskReg(maskReg), .modemIntEn(modemIntEn), .inD2(inD2),
    .sleeping(sleeping), .pmeAck(pmeAck), .modemIrq(modemIrq), .pmeN(pmeN), .wakeReq(wakeReq)
  );

  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].tgt <= cyc) begin
      exp_t e;
      e = expQ.pop_front();
      total++;
      if (modemIrq !== e.irq || wakeReq !== e.wake || pmeN !== !e.pmeLow) begin
        bad++;
        $display("FAIL %s: irq/wake/pmeN actual=%b%b%b expected=%b%b%b",
                 e.tag, modemIrq, wakeReq, pmeN, e.irq, e.wake, !e.pmeLow);
      end
    end
  end

  // lines = {serial, dcd, ri, dsr, cts}
  task automatic step(input logic [4:0] lines, input bit ack, input bit eIrq,
                      input bit eWake, input bit ePme, input string tag);
    exp_t e;
    @(negedge clk);
    {serialIn, dcdIn, riIn, dsrIn, ctsIn} = lines;
    pmeAck = ack;
    e.tgt = cyc + 1; e.irq = eIrq; e.wake = eWake; e.pmeLow = ePme; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    pmeAck = 1'b0;
    e.tgt = cyc + 1; e.irq = 1'b0; e.wake = 1'b0; e.tag = {tag, " after"};
    expQ.push_back(e);
    @(negedge clk);
  endtask

  function automatic logic [4:0] cur();
    return {serialIn, dcdIn, riIn, dsrIn, ctsIn};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    ctsIn = 1'b1; dsrIn = 1'b0; riIn = 1'b0; dcdIn = 1'b0; serialIn = 1'b1;
    maskReg = 8'h00; modemIntEn = 1'b1; inD2 = 1'b0; sleeping = 1'b0; pmeAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (modemIrq !== 1'b0 || wakeReq !== 1'b0 || pmeN !== 1'b1) begin
      bad++;
      $display("FAIL R1: irq/wake/pmeN actual=%b%b%b expected=001", modemIrq, wakeReq, pmeN);
    end
    @(negedge clk);

    step(cur() ^ 5'b00001, 0, 1, 0, 0, "R2 cts fall");
    step(cur() ^ 5'b00001, 0, 1, 0, 0, "R2 cts rise");
    step(cur() ^ 5'b00010, 0, 1, 0, 0, "R2 dsr toggle");
    step(cur() ^ 5'b01000, 0, 1, 0, 0, "R2 dcd toggle");
    step(cur() | 5'b00100, 0, 0, 0, 0, "R3 ri rise ignored");
    step(cur() & 5'b11011, 0, 1, 0, 0, "R3 ri fall");

    modemIntEn = 1'b0;
    step(cur() ^ 5'b00010, 0, 0, 0, 0, "R4 int disabled");
    modemIntEn = 1'b1;

    sleeping = 1'b1; inD2 = 1'b1;
    maskReg = 8'h01; step(cur() ^ 5'b00001, 0, 0, 0, 0, "R7 cts masked");
    maskReg = 8'h02; step(cur() ^ 5'b00010, 0, 0, 0, 0, "R7 dsr masked");
    maskReg = 8'h08; step(cur() ^ 5'b01000, 0, 0, 0, 0, "R7 dcd masked");
    maskReg = 8'h04; step(cur() | 5'b00100, 0, 0, 0, 0, "R7 ri rise masked");
    step(cur() & 5'b11011, 0, 0, 0, 0, "R7 ri fall masked");

    maskReg = 8'h00; inD2 = 1'b0;
    step(cur() ^ 5'b01000, 0, 1, 1, 0, "R6 wake when sleeping");
    sleeping = 1'b0; inD2 = 1'b1;
    step(cur() ^ 5'b00010, 0, 1, 0, 1, "R5 pme set in D2");
    step(cur(), 0, 0, 0, 1, "R5 pme held");
    step(cur(), 1, 0, 0, 0, "R5 pme ack");

    maskReg = 8'h20;
    step(cur() & 5'b01111, 0, 0, 0, 0, "R8 start bit masked");
    step(cur() | 5'b10000, 0, 0, 0, 0, "R8 serial rise");
    maskReg = 8'h00;
    step(cur() & 5'b01111, 0, 0, 0, 1, "R8 start bit pme");
    step(cur() | 5'b10000, 1, 0, 0, 0, "R8 ack after start bit");
    inD2 = 1'b0;
    step(cur() & 5'b01111, 0, 0, 0, 0, "R8 start bit outside D2");
    step(cur() | 5'b10000, 0, 0, 0, 0, "R8 serial idle");

    maskReg = 8'hD0; sleeping = 1'b1; inD2 = 1'b1;
    step(cur() ^ 5'b00001, 0, 1, 1, 1, "R9 reserved bits inert");
    maskReg = 8'h00; sleeping = 1'b0;
    step(cur() ^ 5'b00010, 1, 1, 0, 1, "R10 event beats ack");
    step(cur(), 1, 0, 0, 0, "R10 ack alone clears");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule